// File: doc/BRIEF.md
# Timer Input Capture Unit

This block snapshots a free-running 16-bit timer count when a chosen edge arrives on its trigger input. The trigger is either an external capture pin or the output of an on-chip analog comparator, picked by a source-select input. The trigger passes through a two-stage synchronizer, an optional glitch filter and an edge detector. A qualifying edge copies the count into the capture register and raises a capture flag. The flag can drive an interrupt request.

Software reaches the 16-bit capture register over an 8-bit bus. A shared holding byte makes the two byte accesses behave as one. On a read, the low byte is read first, and that read moves the high half into the holding byte. On a write, the high byte goes into the holding byte first, and the low-byte write then commits both halves together. CPU writes to the capture register are accepted only while the waveform mode uses this register as the counter's TOP value.

The timer counter, the waveform generator and the interrupt controller are outside the block. They connect only through ports.

Top module: `icu_top`

## Requirements
- R1: With the glitch filter off, a trigger change that arrives before rising clock edge E0 is captured on edge E3. The capture register then holds the `cnt_in` value present during the cycle before E3.
- R2: The capture flag is set on the same edge that loads the capture register. A new capture overwrites the register even while the flag is still set. A capture takes priority over any flag clear or CPU write in the same cycle.
- R3: `irq` is high exactly when the flag is set and `cfg_irq_en` is 1. A one-cycle pulse on `irq_ack` clears the flag.
- R4: A bus write to address 2 with data bit 0 set clears the flag. The same write with bit 0 clear leaves the flag unchanged.
- R5: A read of address 0 returns capture bits 7:0 and copies bits 15:8 into the holding byte. A read of address 1 returns the holding byte, not the live register, so a capture between the two reads does not tear the value.
- R6: A write to address 1 loads the holding byte. A write to address 0 while `top_mode` is 1 loads {holding byte, data} into the capture register on that edge.
- R7: While `top_mode` is 0, a write to address 0 leaves the capture register unchanged.
- R8: `cfg_src_cmp` = 0 selects `cap_pin` as the trigger, and 1 selects `cmp_out`. The unselected input has no effect.
- R9: Changing `cfg_src_cmp` while the two inputs differ presents an edge to the detector. If that edge matches the polarity, it captures.
- R10: `cfg_rise` = 1 captures on rising edges and 0 captures on falling edges. The opposite edge is ignored.
- R11: With `cfg_nc_en` = 1, the level seen by the detector changes only after the synchronized trigger has shown the new level on 4 consecutive clock edges. Shorter pulses are dropped, and capture latency grows by 3 clocks (capture on E6).
- R12: After reset, the capture register, the holding byte and the flag are zero and `irq` is low. A read of address 2 returns {6'b0, irq, flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 16 | Current timer count |
| cap_pin | input | 1 | External capture pin (asynchronous) |
| cmp_out | input | 1 | Analog comparator output |
| cfg_src_cmp | input | 1 | Trigger source: 0 pin, 1 comparator |
| cfg_rise | input | 1 | Edge select: 1 rising, 0 falling |
| cfg_nc_en | input | 1 | Glitch filter enable |
| cfg_irq_en | input | 1 | Capture interrupt enable |
| top_mode | input | 1 | Waveform mode uses capture register as TOP |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (zero when not reading) |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench reads the low byte, forces a second capture, and only then reads the high byte. A design that returned the live high byte would hand back a mixed value from two different captures. It checks the exact count captured with the filter off and on. An off-by-one in the synchronizer or filter shifts that count, and a filter that passes 3-cycle pulses produces a spurious flag. It also covers the capture caused by switching the trigger source, low-byte writes outside TOP mode (which must leave the register untouched), and zero writes to the flag bit (which must not clear the flag).

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic src_cmp;
        logic rise;
        logic filt_en;
    } trig_cfg_t;

    function automatic logic edge_hit(input logic now_lvl, input logic old_lvl,
                                      input logic want_rise);
        return (now_lvl != old_lvl) && (now_lvl == want_rise);
    endfunction
endpackage

// File: rtl/icu_trig_cond.sv
module icu_trig_cond
    import icu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NC_LEN      = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_raw,
    input  logic      cmp_raw,
    input  trig_cfg_t cfg,
    output logic      lvl_out
);
    localparam int NC_W = $clog2(NC_LEN + 1);

    logic              trig_raw;
    logic [SYNC_STAGES-1:0] sync_q;
    logic              sync_lvl;
    logic              filt_q;
    logic [NC_W-1:0]   run_q;

    assign trig_raw = cfg.src_cmp ? cmp_raw : pin_raw;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= trig_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b0;
            run_q  <= '0;
        end else if (!cfg.filt_en) begin
            filt_q <= sync_lvl;
            run_q  <= '0;
        end else if (sync_lvl == filt_q) begin
            run_q <= '0;
        end else if (run_q == NC_W'(NC_LEN - 1)) begin
            filt_q <= sync_lvl;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign lvl_out = filt_q;
endmodule

// File: rtl/icu_edge_det.sv
module icu_edge_det
    import icu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic want_rise,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign hit = edge_hit(lvl, prev_q, want_rise);
endmodule

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*BUS_W-1:0] cnt_in,
    input  logic               cap_stb,
    input  logic               top_mode,
    input  logic               irq_ack,
    input  logic               irq_en,
    input  bus_req_t           req,
    output logic [BUS_W-1:0]   rdata,
    output logic [2*BUS_W-1:0] cap_q,
    output logic [BUS_W-1:0]   temp_q,
    output logic               flag_q,
    output logic               irq
);
    logic flag_clr;

    assign flag_clr = irq_ack || (req.wr && req.sel == SEL_FLAG && req.data[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            temp_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (req.rd && req.sel == SEL_LO) temp_q <= cap_q[2*BUS_W-1:BUS_W];
            if (req.wr && req.sel == SEL_HI) temp_q <= req.data[BUS_W-1:0];

            if (cap_stb)
                cap_q <= cnt_in;
            else if (req.wr && req.sel == SEL_LO && top_mode)
                cap_q <= {temp_q, req.data[BUS_W-1:0]};

            if (cap_stb)       flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && irq_en;

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            unique case (req.sel)
                SEL_LO:   rdata = cap_q[BUS_W-1:0];
                SEL_HI:   rdata = temp_q;
                SEL_FLAG: rdata = BUS_W'({irq, flag_q});
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NC_LEN      = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cnt_in,
    input  logic        cap_pin,
    input  logic        cmp_out,
    input  logic        cfg_src_cmp,
    input  logic        cfg_rise,
    input  logic        cfg_nc_en,
    input  logic        cfg_irq_en,
    input  logic        top_mode,
    input  logic        irq_ack,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq
);
    localparam int BUS_W = BYTE_W;

    trig_cfg_t          cfg;
    bus_req_t           req;
    logic               trig_lvl;
    logic               cap_stb;
    logic [2*BUS_W-1:0] cap_q;
    logic [BUS_W-1:0]   temp_q;
    logic               flag_q;

    assign cfg = '{src_cmp: cfg_src_cmp, rise: cfg_rise, filt_en: cfg_nc_en};
    assign req = '{wr: bus_wr, rd: bus_rd, sel: reg_sel_e'(bus_addr), data: bus_wdata};

    icu_trig_cond #(.SYNC_STAGES(SYNC_STAGES), .NC_LEN(NC_LEN)) u_cond (
        .clk(clk), .rst(rst), .pin_raw(cap_pin), .cmp_raw(cmp_out),
        .cfg(cfg), .lvl_out(trig_lvl)
    );

    icu_edge_det u_edge (
        .clk(clk), .rst(rst), .lvl(trig_lvl), .want_rise(cfg.rise), .hit(cap_stb)
    );

    icu_regs #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .cap_stb(cap_stb),
        .top_mode(top_mode), .irq_ack(irq_ack), .irq_en(cfg_irq_en), .req(req),
        .rdata(bus_rdata), .cap_q(cap_q), .temp_q(temp_q), .flag_q(flag_q), .irq(irq)
    );
endmodule

module icu_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cnt_in,
    input logic        cap_stb,
    input logic [15:0] cap_q,
    input logic [7:0]  temp_q,
    input logic        flag_q,
    input logic        irq,
    input logic        irq_ack,
    input logic        irq_en,
    input logic        top_mode,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_wdata
);
    a_r1_capture_value: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> cap_q == $past(cnt_in));

    a_r2_flag_with_capture: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> flag_q);

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !cap_stb) |=> !flag_q);

    a_r3_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    a_r4_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (flag_q && bus_wr && bus_addr == 2'd2 && !bus_wdata[0] && !irq_ack) |=> flag_q);

    a_r6_commit: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && top_mode && !cap_stb)
        |=> cap_q == {$past(temp_q), $past(bus_wdata)});

    a_r7_locked: assert property (@(posedge clk) disable iff (rst)
        (!top_mode && !cap_stb) |=> cap_q == $past(cap_q));
endmodule

bind icu_top icu_chk u_chk (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .cap_stb(cap_stb), .cap_q(cap_q),
    .temp_q(temp_q), .flag_q(flag_q), .irq(irq), .irq_ack(irq_ack),
    .irq_en(cfg_irq_en), .top_mode(top_mode), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/icu_top_tb.sv
module icu_top_tb;
    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tb_cnt = 16'h0000;
    logic        cnt_run = 1'b0;
    logic        cap_pin = 1'b0, cmp_out = 1'b0;
    logic        cfg_src_cmp = 1'b0, cfg_rise = 1'b1, cfg_nc_en = 1'b0, cfg_irq_en = 1'b0;
    logic        top_mode = 1'b0, irq_ack = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        irq;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    logic [15:0] c0;

    always #4 clk = ~clk;

    always @(negedge clk) if (cnt_run) tb_cnt <= tb_cnt + 16'd1;

    icu_top u_dut (
        .clk(clk), .rst(rst), .cnt_in(tb_cnt), .cap_pin(cap_pin), .cmp_out(cmp_out),
        .cfg_src_cmp(cfg_src_cmp), .cfg_rise(cfg_rise), .cfg_nc_en(cfg_nc_en),
        .cfg_irq_en(cfg_irq_en), .top_mode(top_mode), .irq_ack(irq_ack),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: samples mid-phase, pops the expected item, compares.
    always @(negedge clk) begin
        #2;
        if (bus_rd) begin
            item_t it;
            if (q.size() == 0) begin
                mismatched++;
                $display("FAIL scoreboard: read with no expected item, got %02h expected none", bus_rdata);
            end else begin
                it = q.pop_front();
                compared++;
                if (bus_rdata !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: got %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
        bus_addr = a;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic clr_flag();
        wr(2'd2, 8'h01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        // R12 reset state
        rd(2'd0, 8'h00, "R12 low byte after reset");
        rd(2'd1, 8'h00, "R12 high byte after reset");
        rd(2'd2, 8'h00, "R12 flag/irq after reset");

        // R1 / R8 pin rising capture
        tb_cnt = 16'h1234;
        @(negedge clk); cap_pin = 1'b1;
        tick(6);
        rd(2'd2, 8'h01, "R2 flag set by capture");
        rd(2'd0, 8'h34, "R1 captured low byte");
        rd(2'd1, 8'h12, "R5 captured high byte via holding");

        // R10 falling edge ignored in rising mode
        clr_flag();
        tb_cnt = 16'h5555;
        @(negedge clk); cap_pin = 1'b0;
        tick(6);
        rd(2'd2, 8'h00, "R10 opposite edge ignored");
        rd(2'd0, 8'h34, "R10 register kept");

        // R5 atomic read across a capture
        rd(2'd0, 8'h34, "R5 low read loads holding");
        tb_cnt = 16'hABCD;
        @(negedge clk); cap_pin = 1'b1;
        tick(6);
        rd(2'd1, 8'h12, "R5 high read returns holding not live");
        rd(2'd0, 8'hCD, "R5 new low byte");
        rd(2'd1, 8'hAB, "R5 new high byte");

        // R4 zero write, R3 irq and ack
        wr(2'd2, 8'h00);
        rd(2'd2, 8'h01, "R4 zero write keeps flag");
        cfg_irq_en = 1'b1;
        rd(2'd2, 8'h03, "R3 irq raised");
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        rd(2'd2, 8'h00, "R3 ack clears flag");

        // R10 falling mode, R2 overwrite while flag set
        cfg_rise = 1'b0;
        tb_cnt = 16'h1111;
        @(negedge clk); cap_pin = 1'b0;
        tick(6);
        rd(2'd2, 8'h03, "R10 falling edge captures");
        cfg_rise = 1'b1;
        tb_cnt = 16'h2222;
        @(negedge clk); cap_pin = 1'b1;
        tick(6);
        rd(2'd0, 8'h22, "R2 overwrite while flag set low");
        rd(2'd1, 8'h22, "R2 overwrite while flag set high");
        cfg_irq_en = 1'b0;
        clr_flag();

        // R7 writes locked outside TOP mode
        top_mode = 1'b0;
        wr(2'd1, 8'h77);
        wr(2'd0, 8'h88);
        rd(2'd0, 8'h22, "R7 low write ignored");
        rd(2'd1, 8'h22, "R7 high unchanged");

        // R6 write in TOP mode
        top_mode = 1'b1;
        wr(2'd1, 8'h9A);
        wr(2'd0, 8'hBC);
        top_mode = 1'b0;
        rd(2'd0, 8'hBC, "R6 committed low byte");
        rd(2'd1, 8'h9A, "R6 committed high byte");

        // R9 source switch causes capture
        @(negedge clk); cap_pin = 1'b0;
        tick(6);
        clr_flag();
        cmp_out = 1'b1;
        tb_cnt = 16'h3C3C;
        tick(2);
        cfg_src_cmp = 1'b1;
        tick(6);
        rd(2'd2, 8'h01, "R9 switch captured");
        rd(2'd0, 8'h3C, "R9 captured low");

        // R8 comparator path, pin ignored
        clr_flag();
        @(negedge clk); cap_pin = 1'b1;
        tick(6);
        rd(2'd2, 8'h00, "R8 pin ignored while comparator selected");
        cfg_rise = 1'b0;
        tb_cnt = 16'h4D4D;
        @(negedge clk); cmp_out = 1'b0;
        tick(6);
        rd(2'd2, 8'h01, "R8 comparator edge captures");
        rd(2'd0, 8'h4D, "R8 comparator capture value");
        cfg_src_cmp = 1'b0;
        tick(6);
        cfg_rise = 1'b1;
        @(negedge clk); cap_pin = 1'b0;
        tick(6);
        clr_flag();

        // R1 latency without filter
        cnt_run = 1'b1;
        @(negedge clk); cap_pin = 1'b1; #1 c0 = tb_cnt;
        tick(8);
        cnt_run = 1'b0;
        rd(2'd0, 8'(c0 + 16'd3), "R1 latency low byte");
        rd(2'd1, 8'((c0 + 16'd3) >> 8), "R1 latency high byte");

        // R11 glitch filter
        @(negedge clk); cap_pin = 1'b0;
        tick(6);
        clr_flag();
        cfg_nc_en = 1'b1;
        tick(2);
        @(negedge clk); cap_pin = 1'b1;
        tick(3);
        cap_pin = 1'b0;
        tick(8);
        rd(2'd2, 8'h00, "R11 3-cycle pulse dropped");
        cnt_run = 1'b1;
        @(negedge clk); cap_pin = 1'b1; #1 c0 = tb_cnt;
        tick(10);
        cnt_run = 1'b0;
        rd(2'd2, 8'h01, "R11 held level captured");
        rd(2'd0, 8'(c0 + 16'd6), "R11 filtered latency low");
        rd(2'd1, 8'((c0 + 16'd6) >> 8), "R11 filtered latency high");

        tick(3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule